// File: doc/BRIEF.md
# Instruction-Framed Serial Register Port

This block is the slave side of a serial link that gives a host access to a converter's register bank. The host drives a serial clock and one data line, and may use an active-low select. Every transaction opens with an instruction byte. That byte names the direction, the number of data bytes (one to three) and the byte address where access begins. The data bytes then follow. Input bits are captured on the falling serial clock edge. Read bits are launched after the rising edge on a data-out / output-enable pair, which the pad ring turns into the bidirectional pin.

The block holds four registers that the rest of the converter uses: a 16-bit data word, a 16-bit command word, a 24-bit offset trim and a 24-bit full-scale trim. Two bits of the command word change the framing. One makes the byte address count down instead of up. The other moves the bits of each data byte least-significant first. The data and command words change only when a write transaction ends, so a consumer never sees a half-written value. If the serial clock stalls partway through a transaction, a timeout returns the port to waiting for an instruction.

All serial inputs pass through a synchroniser into the system clock domain. The serial clock must therefore run at no more than one tenth of the system clock rate.

Top module: `serial_regport`

## Requirements
- R1: After reset, the data word and both trim registers read zero, the command word is 16'h0022 (mode field bits1:0 = 2'b10, data-format bit5 = 1) and the output enable is low.
- R2: The instruction byte is always taken most-significant bit first. Its fields are: bit7 = direction (0 write, 1 read); bits6:5 = byte-count code (00 one byte, 01 two bytes, 10 three bytes); bits3:0 = start address.
- R3: The byte addresses are: 0/1 = data word high/low; 4/5 = command word high/low; 8/9/10 = offset trim bits 23:16/15:8/7:0; 12/13/14 = full-scale trim bits 23:16/15:8/7:0. A write to any other address changes nothing, and a read from one returns 8'h00.
- R4: After each data byte, the address moves down by one when command bit3 is 1 and up by one when it is 0. Writes to addresses 4 and 5 always step upward, whatever bit3 holds.
- R5: When command bit2 is 1, each data byte (read or written) moves least-significant bit first. When it is 0, each data byte moves most-significant bit first. The instruction byte is not affected by bit2.
- R6: The data word and the command word take their new values only at the falling edge of the last bit of the last byte of a write transaction. Before that point, the outputs keep their old values.
- R7: The output enable goes high once a read instruction is complete. It stays high through the data phase and falls after the last bit of the last byte. A new output bit is presented after each rising serial clock edge. The output enable stays low during writes.
- R8: A falling serial clock edge that arrives while the port waits for an instruction and the select input is high is ignored. With select held low, transactions may follow one another with no gap.
- R9: If no serial clock edge arrives for TIMEOUT system clocks while a transaction is part-way through, the port returns to waiting for an instruction. The outputs keep their values.
- R10: When a command write commits with command bit6 (clear) set, the data word becomes zero in the same commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_sel_n_i | input | 1 | Active-low select |
| ser_data_i | input | 1 | Serial data from the pin |
| ser_data_o | output | 1 | Serial data toward the pin |
| ser_data_oe | output | 1 | Drive enable for the pin |
| data_reg_o | output | 16 | Committed data word |
| cmd_reg_o | output | 16 | Committed command word |
| offset_reg_o | output | 24 | Offset trim register |
| fullscale_reg_o | output | 24 | Full-scale trim register |

## Verification
The bench sets the byte-order bit and then writes the command word. A design that decremented on command writes would leave the old command word in place. A mid-transfer check of the data word catches a design that commits per byte instead of at the end. Bit order is tested with asymmetric bytes (80 and 01), so a swapped bit order shows up as a wrong value. A stalled transfer followed by a fresh one-byte write shows whether the timeout restarts instruction parsing: without it, the new instruction bits would be absorbed as data. Further tests cover a write with select high, a reserved-address access and a clearing command write. Each of these would leave visibly wrong register outputs on a design that got it wrong.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int TRIM_W = 24;

  typedef enum logic {PH_INSTR, PH_DATA} phase_t;

  localparam logic [3:0] ADR_DATA_HI = 4'd0;
  localparam logic [3:0] ADR_DATA_LO = 4'd1;
  localparam logic [3:0] ADR_CMD_HI  = 4'd4;
  localparam logic [3:0] ADR_CMD_LO  = 4'd5;
  localparam logic [3:0] ADR_OFS_B2  = 4'd8;
  localparam logic [3:0] ADR_OFS_B1  = 4'd9;
  localparam logic [3:0] ADR_OFS_B0  = 4'd10;
  localparam logic [3:0] ADR_FS_B2   = 4'd12;
  localparam logic [3:0] ADR_FS_B1   = 4'd13;
  localparam logic [3:0] ADR_FS_B0   = 4'd14;

  localparam int CB_CLEAR     = 6;
  localparam int CB_BYTE_DOWN = 3;
  localparam int CB_LSB_FIRST = 2;

  localparam logic [WORD_W-1:0] CMD_RESET = 16'h0022;

  function automatic logic [1:0] last_byte_idx(input logic [1:0] code);
    return (code == 2'b00) ? 2'd0 : (code == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic addr_mapped(input logic [3:0] a);
    return (a == ADR_DATA_HI) || (a == ADR_DATA_LO) || (a == ADR_CMD_HI) ||
           (a == ADR_CMD_LO)  || (a == ADR_OFS_B2)  || (a == ADR_OFS_B1) ||
           (a == ADR_OFS_B0)  || (a == ADR_FS_B2)   || (a == ADR_FS_B1)  ||
           (a == ADR_FS_B0);
  endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= stg_q[g-1];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sreg_proto.sv
module sreg_proto
  import sreg_pkg::*;
#(
  parameter int TIMEOUT = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic             seln_s,
  input  logic             byte_dn,
  input  logic             lsb_first,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [3:0]       addr,
  output logic             wr_en,
  output logic [BYTE_W-1:0] wr_byte,
  output logic             commit,
  output logic             abort,
  output logic             sdo,
  output logic             oe
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(TIMEOUT);

  phase_t           phase_q, phase_n;
  logic [2:0]       bit_q, bit_n;
  logic [1:0]       left_q, left_n;
  logic [3:0]       addr_q, addr_n;
  logic             rd_q, rd_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [CW-1:0]    idle_q, idle_n;
  logic             sdo_q, sdo_n, oe_q, oe_n, sclk_q;

  logic rise, fall, busy, accept, byte_done, step_up;
  logic [BYTE_W-1:0] byte_in;
  logic [3:0] addr_step;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign busy      = (phase_q == PH_DATA) || (bit_q != 3'd0);
  assign abort     = busy && (idle_q == IDLE_MAX);
  assign accept    = fall && !abort && !(phase_q == PH_INSTR && bit_q == 3'd0 && seln_s);
  assign byte_done = accept && (bit_q == 3'd7);
  assign byte_in   = (phase_q == PH_INSTR || !lsb_first) ? {sh_q[6:0], sdi_s}
                                                         : {sdi_s, sh_q[7:1]};
  assign step_up   = !byte_dn || (!rd_q && (addr_q == ADR_CMD_HI || addr_q == ADR_CMD_LO));
  assign addr_step = step_up ? addr_q + 4'd1 : addr_q - 4'd1;

  always_comb begin
    phase_n = phase_q; bit_n = bit_q; left_n = left_q; addr_n = addr_q;
    rd_n = rd_q; sh_n = sh_q; sdo_n = sdo_q; oe_n = oe_q;
    wr_en = 1'b0; commit = 1'b0;
    idle_n = (!busy || rise || fall || abort) ? '0 : idle_q + CW'(1);
    if (abort) begin
      phase_n = PH_INSTR; bit_n = 3'd0; oe_n = 1'b0;
    end else if (accept) begin
      bit_n = bit_q + 3'd1;
      sh_n  = byte_in;
      if (byte_done) begin
        if (phase_q == PH_INSTR) begin
          rd_n    = byte_in[7];
          left_n  = last_byte_idx(byte_in[6:5]);
          addr_n  = byte_in[3:0];
          phase_n = PH_DATA;
          oe_n    = byte_in[7];
        end else begin
          wr_en  = !rd_q;
          commit = !rd_q && (left_q == 2'd0);
          if (left_q == 2'd0) begin
            phase_n = PH_INSTR; oe_n = 1'b0;
          end else begin
            left_n = left_q - 2'd1; addr_n = addr_step;
          end
        end
      end
    end
    if (rise && phase_q == PH_DATA && rd_q)
      sdo_n = lsb_first ? rd_byte[bit_q] : rd_byte[3'd7 - bit_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR; bit_q <= '0; left_q <= '0; addr_q <= '0;
      rd_q <= 1'b0; sh_q <= '0; idle_q <= '0; sdo_q <= 1'b0;
      oe_q <= 1'b0; sclk_q <= 1'b0;
    end else begin
      phase_q <= phase_n; bit_q <= bit_n; left_q <= left_n; addr_q <= addr_n;
      rd_q <= rd_n; sh_q <= sh_n; idle_q <= idle_n; sdo_q <= sdo_n;
      oe_q <= oe_n; sclk_q <= sclk_s;
    end
  end

  assign addr    = addr_q;
  assign wr_byte = byte_in;
  assign sdo     = sdo_q;
  assign oe      = oe_q;

  a_r9_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= IDLE_MAX);
  a_r9_abort_home: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (phase_q == PH_INSTR && bit_q == 3'd0 && !oe_q));
  a_r8_sel_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && seln_s && phase_q == PH_INSTR && bit_q == 3'd0) |=>
      (phase_q == PH_INSTR && bit_q == 3'd0));
  a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && !rd_q) |-> !oe_q);
  a_r4_cmd_write_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_q == ADR_CMD_HI && !commit) |=> (addr_q == ADR_CMD_LO));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              commit,
  input  logic              abort,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] cmd_q,
  output logic [TRIM_W-1:0] ofs_q,
  output logic [TRIM_W-1:0] fs_q
);
  logic [WORD_W-1:0] sh_data_q, sh_data_n, sh_cmd_q, sh_cmd_n, data_n, cmd_n;
  logic [TRIM_W-1:0] ofs_n, fs_n;

  always_comb begin
    sh_data_n = sh_data_q; sh_cmd_n = sh_cmd_q;
    ofs_n = ofs_q; fs_n = fs_q; data_n = data_q; cmd_n = cmd_q;
    if (wr_en) begin
      case (addr)
        ADR_DATA_HI: sh_data_n[15:8] = wr_byte;
        ADR_DATA_LO: sh_data_n[7:0]  = wr_byte;
        ADR_CMD_HI:  sh_cmd_n[15:8]  = wr_byte;
        ADR_CMD_LO:  sh_cmd_n[7:0]   = wr_byte;
        ADR_OFS_B2:  ofs_n[23:16]    = wr_byte;
        ADR_OFS_B1:  ofs_n[15:8]     = wr_byte;
        ADR_OFS_B0:  ofs_n[7:0]      = wr_byte;
        ADR_FS_B2:   fs_n[23:16]     = wr_byte;
        ADR_FS_B1:   fs_n[15:8]      = wr_byte;
        ADR_FS_B0:   fs_n[7:0]       = wr_byte;
        default: ;
      endcase
    end
    if (commit) begin
      cmd_n     = sh_cmd_n;
      data_n    = sh_cmd_n[CB_CLEAR] ? '0 : sh_data_n;
      sh_data_n = data_n;
    end
    if (abort) begin
      sh_data_n = data_q; sh_cmd_n = cmd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data_q <= '0; sh_cmd_q <= CMD_RESET; data_q <= '0; cmd_q <= CMD_RESET;
      ofs_q <= '0; fs_q <= '0;
    end else begin
      sh_data_q <= sh_data_n; sh_cmd_q <= sh_cmd_n; data_q <= data_n;
      cmd_q <= cmd_n; ofs_q <= ofs_n; fs_q <= fs_n;
    end
  end

  always_comb begin
    case (addr)
      ADR_DATA_HI: rd_byte = data_q[15:8];
      ADR_DATA_LO: rd_byte = data_q[7:0];
      ADR_CMD_HI:  rd_byte = cmd_q[15:8];
      ADR_CMD_LO:  rd_byte = cmd_q[7:0];
      ADR_OFS_B2:  rd_byte = ofs_q[23:16];
      ADR_OFS_B1:  rd_byte = ofs_q[15:8];
      ADR_OFS_B0:  rd_byte = ofs_q[7:0];
      ADR_FS_B2:   rd_byte = fs_q[23:16];
      ADR_FS_B1:   rd_byte = fs_q[15:8];
      ADR_FS_B0:   rd_byte = fs_q[7:0];
      default:     rd_byte = '0;
    endcase
  end

  a_r6_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(data_q) && $stable(cmd_q)));
  a_r10_clear_data: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!cmd_q[CB_CLEAR] || data_q == '0));
  a_r3_reserved_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_mapped(addr)) |=> ($stable(ofs_q) && $stable(fs_q)));
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import sreg_pkg::*;
#(
  parameter int TIMEOUT     = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_sel_n_i,
  input  logic              ser_data_i,
  output logic              ser_data_o,
  output logic              ser_data_oe,
  output logic [WORD_W-1:0] data_reg_o,
  output logic [WORD_W-1:0] cmd_reg_o,
  output logic [TRIM_W-1:0] offset_reg_o,
  output logic [TRIM_W-1:0] fullscale_reg_o
);
  logic [2:0] sync_q;
  logic [3:0] addr;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic wr_en, commit, abort;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_sel_n_i, ser_data_i, ser_clk_i}), .q(sync_q));

  sreg_proto #(.TIMEOUT(TIMEOUT)) u_proto (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sync_q[0]), .sdi_s(sync_q[1]), .seln_s(sync_q[2]),
    .byte_dn(cmd_reg_o[CB_BYTE_DOWN]), .lsb_first(cmd_reg_o[CB_LSB_FIRST]),
    .rd_byte(rd_byte), .addr(addr), .wr_en(wr_en), .wr_byte(wr_byte),
    .commit(commit), .abort(abort), .sdo(ser_data_o), .oe(ser_data_oe));

  sreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_byte(wr_byte),
    .commit(commit), .abort(abort), .rd_byte(rd_byte),
    .data_q(data_reg_o), .cmd_q(cmd_reg_o),
    .ofs_q(offset_reg_o), .fs_q(fullscale_reg_o));
endmodule

// File: tb/tb_serial_regport.sv
module tb_serial_regport;
  localparam int HB = 8;
  localparam int TMO = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, sel_n = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  logic [15:0] data_o, cmd_o;
  logic [23:0] ofs_o, fs_o;
  int checks = 0, errors = 0;
  logic [7:0] mdl [16];

  always #10 clk = ~clk;

  serial_regport #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_sel_n_i(sel_n),
    .ser_data_i(sdi), .ser_data_o(sdo), .ser_data_oe(oe),
    .data_reg_o(data_o), .cmd_reg_o(cmd_o),
    .offset_reg_o(ofs_o), .fullscale_reg_o(fs_o));

  // entries: {start address, byte count, payload with first byte in [23:16]}
  localparam logic [29:0] VEC [7] = '{
    {4'd0,  2'd2, 24'hA55A00}, {4'd8,  2'd3, 24'h123456},
    {4'd12, 2'd3, 24'hFEDCBA}, {4'd1,  2'd1, 24'h3C0000},
    {4'd13, 2'd1, 24'h770000}, {4'd2,  2'd1, 24'hEE0000},
    {4'd9,  2'd2, 24'h998800}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    ser_clk = 1'b1; sdi = b; tick(HB);
    ser_clk = 1'b0; tick(HB);
  endtask

  task automatic get_bit(output logic b);
    ser_clk = 1'b1; tick(HB); b = sdo;
    ser_clk = 1'b0; tick(HB);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lsb);
    for (int i = 0; i < 8; i++) put_bit(lsb ? b[i] : b[7-i]);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit lsb);
    logic x;
    for (int i = 0; i < 8; i++) begin
      get_bit(x);
      if (lsb) b[i] = x; else b[7-i] = x;
    end
  endtask

  function automatic logic [1:0] cnt_code(input int n);
    return (n == 1) ? 2'b00 : (n == 2) ? 2'b01 : 2'b10;
  endfunction

  function automatic bit mapped(input logic [3:0] a);
    return a inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14};
  endfunction

  task automatic wr_seq(input logic [3:0] a, input int n, input logic [23:0] pl, input bit lsb);
    send_byte({1'b0, cnt_code(n), 1'b0, a}, 1'b0);
    for (int i = 0; i < n; i++) send_byte(pl[23-8*i -: 8], lsb);
  endtask

  task automatic rd_seq(input logic [3:0] a, input int n, input bit lsb, output logic [23:0] got);
    logic [7:0] b;
    got = '0;
    send_byte({1'b1, cnt_code(n), 1'b0, a}, 1'b0);
    chk("R7 oe high after read instruction", {31'd0, oe}, 32'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, lsb);
      got[23-8*i -: 8] = b;
    end
    chk("R7 oe low after last read bit", {31'd0, oe}, 32'd0);
  endtask

  task automatic chk_ports(input string tag);
    chk({tag, " data"}, {16'd0, data_o}, {16'd0, mdl[0], mdl[1]});
    chk({tag, " offset"}, {8'd0, ofs_o}, {8'd0, mdl[8], mdl[9], mdl[10]});
    chk({tag, " fullscale"}, {8'd0, fs_o}, {8'd0, mdl[12], mdl[13], mdl[14]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] got;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    chk("R1 reset cmd", {16'd0, cmd_o}, 32'h0022);
    chk("R1 reset oe", {31'd0, oe}, 32'd0);
    chk_ports("R1 reset");

    // R2 R3 table of write then readback, ascending MSB-first
    for (int v = 0; v < 7; v++) begin
      logic [3:0] a; int n; logic [23:0] pl;
      a = VEC[v][29:26]; n = int'(VEC[v][25:24]); pl = VEC[v][23:0];
      wr_seq(a, n, pl, 1'b0);
      for (int i = 0; i < n; i++)
        if (mapped(a + 4'(i))) mdl[a + 4'(i)] = pl[23-8*i -: 8];
      chk_ports("R2 R3 table write");
      rd_seq(a, n, 1'b0, got);
      for (int i = 0; i < n; i++)
        chk("R3 table readback", {24'd0, got[23-8*i -: 8]}, {24'd0, mdl[a + 4'(i)]});
    end

    // R6 data word must not change between the two bytes
    send_byte(8'h20, 1'b0);
    send_byte(8'h11, 1'b0);
    chk("R6 data unchanged mid transfer", {16'd0, data_o}, {16'd0, mdl[0], mdl[1]});
    send_byte(8'h22, 1'b0);
    mdl[0] = 8'h11; mdl[1] = 8'h22;
    chk("R6 data after last byte", {16'd0, data_o}, 32'h1122);

    // R4 descending address, command writes still ascend
    wr_seq(4'd4, 2, 24'h002A00, 1'b0);
    chk("R4 cmd byte-down set", {16'd0, cmd_o}, 32'h002A);
    wr_seq(4'd10, 3, 24'h112233, 1'b0);
    mdl[10] = 8'h11; mdl[9] = 8'h22; mdl[8] = 8'h33;
    chk("R4 descending offset write", {8'd0, ofs_o}, 32'h332211);
    rd_seq(4'd10, 3, 1'b0, got);
    chk("R4 descending readback", {8'd0, got}, 32'h112233);
    wr_seq(4'd4, 2, 24'h002200, 1'b0);
    chk("R4 cmd write ascends with byte-down", {16'd0, cmd_o}, 32'h0022);

    // R5 LSB-first data bytes, instruction stays MSB-first
    wr_seq(4'd4, 2, 24'h002600, 1'b0);
    chk("R5 cmd lsb-first set", {16'd0, cmd_o}, 32'h0026);
    wr_seq(4'd0, 2, 24'h800100, 1'b1);
    mdl[0] = 8'h80; mdl[1] = 8'h01;
    chk("R5 lsb-first data write", {16'd0, data_o}, 32'h8001);
    rd_seq(4'd0, 2, 1'b1, got);
    chk("R5 lsb-first readback", {8'd0, got}, 32'h800100);
    wr_seq(4'd4, 2, 24'h002200, 1'b1);
    chk("R5 cmd restored lsb-first", {16'd0, cmd_o}, 32'h0022);

    // R10 clear bit zeroes data word
    wr_seq(4'd4, 2, 24'h006200, 1'b0);
    mdl[0] = 8'h00; mdl[1] = 8'h00;
    chk("R10 cmd with clear", {16'd0, cmd_o}, 32'h0062);
    chk("R10 data cleared", {16'd0, data_o}, 32'h0000);
    wr_seq(4'd4, 2, 24'h002200, 1'b0);
    chk("R10 data stays zero", {16'd0, data_o}, 32'h0000);

    // R8 select high ignores, then back-to-back with select low
    sel_n = 1'b1; tick(4);
    wr_seq(4'd0, 2, 24'hFFFF00, 1'b0);
    sel_n = 1'b0; tick(4);
    chk("R8 deselected write ignored", {16'd0, data_o}, 32'h0000);
    wr_seq(4'd0, 1, 24'h420000, 1'b0);
    wr_seq(4'd1, 1, 24'h240000, 1'b0);
    mdl[0] = 8'h42; mdl[1] = 8'h24;
    chk("R8 back-to-back writes", {16'd0, data_o}, 32'h4224);

    // R9 stalled transfer abandoned, next instruction parsed fresh
    send_byte(8'h20, 1'b0);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    tick(TMO + 200);
    chk("R9 oe low after stall", {31'd0, oe}, 32'd0);
    chk("R9 data untouched by stall", {16'd0, data_o}, 32'h4224);
    wr_seq(4'd1, 1, 24'h5A0000, 1'b0);
    mdl[1] = 8'h5A;
    chk("R9 fresh instruction after timeout", {16'd0, data_o}, 32'h425A);
    chk_ports("R9 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule